// File: doc/BRIEF.md
# Processor exception entry sequencer

This block performs the hardware side of taking an exception in a 32-bit processor that runs in either a full 32-bit instruction state or a compressed 16-bit instruction state. Each cycle it looks at seven exception request lines, the current program counter and the current status word. The state flag is bit 5 of that word. When a request is accepted, the block does four things in one step. It stores a return link in the link register banked for the target mode. It copies the whole status word into that mode's banked saved-status register. It presents a new status word with the mode field, the mask bits and the state flag rewritten. It presents the vector address as the fetch redirect.

The link value depends on both the exception kind and the interrupted instruction state. A handler can therefore resume with one fixed return rule per kind, without knowing which state it interrupted. The block also performs a return operation. It reads the banks of the current mode, presents the link less the per-kind return offset as the new PC, and presents the saved status as the new status. Any masks set on entry are dropped in the same step.

All results are registered. They appear one clock after the request, together with a one-cycle valid strobe. The surrounding pipeline applies them.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, every output is zero. All banked link and saved-status registers reset to zero.
- R2: The bit positions of `exc_req` are: 0 reset, 1 undefined instruction, 2 software interrupt, 3 prefetch abort, 4 data abort, 5 IRQ, 6 FIQ. When several eligible requests are present, exactly one is taken. The priority order is reset, data abort, FIQ, IRQ, prefetch abort, undefined instruction, software interrupt.
- R3: An IRQ request is not eligible while `psr_in[7]` is set. An FIQ request is not eligible while `psr_in[6]` is set. A masked request on its own produces no output.
- R4: With `psr_in[5]` = 0 (32-bit state), the link value is `pc_in`+8 for data abort and `pc_in`+4 for every other kind except reset.
- R5: With `psr_in[5]` = 1 (16-bit state), the link value is `pc_in`+2 for undefined instruction and software interrupt, `pc_in`+4 for IRQ, FIQ and prefetch abort, and `pc_in`+8 for data abort.
- R6: The status word after entry equals `psr_in` with these changes: bits 4:0 are set to the target mode, bit 7 is set, bit 5 is cleared, and bit 6 is set for reset and FIQ. The target modes are 10011 for reset and software interrupt, 11011 for undefined instruction, 10111 for both aborts, 10010 for IRQ and 10001 for FIQ.
- R7: The redirect PC on entry is the vector address. The vectors are 0x00 reset, 0x04 undefined, 0x08 software interrupt, 0x0C prefetch abort, 0x10 data abort, 0x18 IRQ and 0x1C FIQ.
- R8: Entry stores `psr_in` in the saved-status bank of the target mode. A return (`ret_req`) in that mode presents the saved word as `psr_out`.
- R9: A return presents `redir_pc` = banked link − offset, where the offset comes from `ret_kind` (same encoding as R2). The offset is 0 for reset, undefined instruction and software interrupt, 8 for data abort, and 4 for all other codes.
- R10: Reset entry writes neither bank and leaves `link_we` low. Every other entry raises `link_we` and shows the stored link on `link_val`. `link_val` is zero whenever `link_we` is low.
- R11: A return requested while `psr_in[4:0]` is not one of the five exception modes, or in the same cycle as an accepted exception, has no effect. An exception takes precedence over a return.
- R12: Every accepted entry or return raises `redir_valid` for exactly the following cycle. While `redir_valid` is low, `redir_pc` and `psr_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| exc_req | input | 7 | Exception request lines, one per kind |
| ret_req | input | 1 | Return operation request |
| ret_kind | input | 3 | Exception kind being returned from |
| pc_in | input | XLEN | Current program counter |
| psr_in | input | 32 | Current status word, state flag at bit 5 |
| redir_valid | output | 1 | New PC and status are valid this cycle |
| redir_pc | output | XLEN | Vector address or return address |
| psr_out | output | 32 | New status word |
| link_we | output | 1 | An entry wrote a banked link register |
| link_val | output | XLEN | Value written into the link register |

## Verification
Every kind is raised on its own in both instruction states. This separates the 32-bit and 16-bit link offsets, and it separates the vector and mode of each kind. Combined request patterns go through the priority chain one pair at a time. Masked interrupts are driven both alone and alongside a lower request, which shows that masking drops only the masked line. Returns follow entries into each mode, including an entry after a reset request that must leave the supervisor bank untouched. Returns from user mode and returns that collide with an exception show that those returns are ignored.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  localparam int NUM_KINDS = 7;
  localparam int NUM_BANKS = 5;
  localparam int BANK_IW   = $clog2(NUM_BANKS);
  localparam int PSR_W     = 32;

  typedef enum logic [2:0] {
    K_RST = 3'd0, K_UND = 3'd1, K_SWI = 3'd2, K_PAB = 3'd3,
    K_DAB = 3'd4, K_IRQ = 3'd5, K_FIQ = 3'd6, K_NONE = 3'd7
  } exc_kind_e;

  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;

  // distance from the faulting PC to the stored link
  function automatic logic [3:0] link_offset(exc_kind_e k, logic thumb);
    case (k)
      K_DAB:        return 4'd8;
      K_UND, K_SWI: return thumb ? 4'd2 : 4'd4;
      default:      return 4'd4;
    endcase
  endfunction

  // amount taken off the link when resuming
  function automatic logic [3:0] return_offset(exc_kind_e k);
    case (k)
      K_RST, K_UND, K_SWI: return 4'd0;
      K_DAB:               return 4'd8;
      default:             return 4'd4;
    endcase
  endfunction

  function automatic logic [4:0] vector_addr(exc_kind_e k);
    case (k)
      K_IRQ:   return 5'h18;
      K_FIQ:   return 5'h1C;
      default: return {k, 2'b00};
    endcase
  endfunction

  function automatic logic [4:0] target_mode(exc_kind_e k);
    case (k)
      K_UND:        return MODE_UND;
      K_PAB, K_DAB: return MODE_ABT;
      K_IRQ:        return MODE_IRQ;
      K_FIQ:        return MODE_FIQ;
      default:      return MODE_SVC;
    endcase
  endfunction

  // {hit, bank index}
  function automatic logic [BANK_IW:0] bank_of_mode(logic [4:0] m);
    case (m)
      MODE_FIQ: return {1'b1, BANK_IW'(0)};
      MODE_IRQ: return {1'b1, BANK_IW'(1)};
      MODE_SVC: return {1'b1, BANK_IW'(2)};
      MODE_ABT: return {1'b1, BANK_IW'(3)};
      MODE_UND: return {1'b1, BANK_IW'(4)};
      default:  return '0;
    endcase
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_seq_pkg::*;
(
  input  logic [NUM_KINDS-1:0] req,
  input  logic                 irq_masked,
  input  logic                 fiq_masked,
  output logic                 grant_vld,
  output exc_kind_e            grant_kind
);
  logic [NUM_KINDS-1:0] elig;

  always_comb begin
    elig = req;
    elig[K_IRQ] = req[K_IRQ] & ~irq_masked;
    elig[K_FIQ] = req[K_FIQ] & ~fiq_masked;
  end

  always_comb begin
    grant_vld  = 1'b1;
    if      (elig[K_RST]) grant_kind = K_RST;
    else if (elig[K_DAB]) grant_kind = K_DAB;
    else if (elig[K_FIQ]) grant_kind = K_FIQ;
    else if (elig[K_IRQ]) grant_kind = K_IRQ;
    else if (elig[K_PAB]) grant_kind = K_PAB;
    else if (elig[K_UND]) grant_kind = K_UND;
    else if (elig[K_SWI]) grant_kind = K_SWI;
    else begin
      grant_vld  = 1'b0;
      grant_kind = K_NONE;
    end
  end
endmodule

// File: rtl/exc_bank_file.sv
module exc_bank_file
  import exc_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [BANK_IW-1:0] wr_idx,
  input  logic [XLEN-1:0]    wr_link,
  input  logic [PSR_W-1:0]   wr_psr,
  input  logic [BANK_IW-1:0] rd_idx,
  output logic [XLEN-1:0]    rd_link,
  output logic [PSR_W-1:0]   rd_psr
);
  logic [XLEN-1:0]  link_q [NUM_BANKS];
  logic [PSR_W-1:0] spsr_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        link_q[b] <= '0;
        spsr_q[b] <= '0;
      end else if (wr_en && wr_idx == BANK_IW'(b)) begin
        link_q[b] <= wr_link;
        spsr_q[b] <= wr_psr;
      end
    end
  end

  always_comb begin
    rd_link = '0;
    rd_psr  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (rd_idx == BANK_IW'(b)) begin
        rd_link = link_q[b];
        rd_psr  = spsr_q[b];
      end
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_KINDS-1:0] exc_req,
  input  logic                 ret_req,
  input  logic [2:0]           ret_kind,
  input  logic [XLEN-1:0]      pc_in,
  input  logic [PSR_W-1:0]     psr_in,
  output logic                 redir_valid,
  output logic [XLEN-1:0]      redir_pc,
  output logic [PSR_W-1:0]     psr_out,
  output logic                 link_we,
  output logic [XLEN-1:0]      link_val
);
  localparam int OFF_PAD = XLEN - 4;
  localparam int VEC_PAD = XLEN - 5;

  logic            grant_vld;
  exc_kind_e       grant_kind;
  logic            entry_fire;
  logic            bank_wr;
  logic [XLEN-1:0] entry_link;
  logic [PSR_W-1:0] entry_psr;
  logic [BANK_IW:0] wr_bank, rd_bank;
  logic            ret_fire;
  logic [XLEN-1:0] rd_link;
  logic [PSR_W-1:0] rd_psr;
  logic            entry_q;

  exc_arbiter u_arb (
    .req        (exc_req),
    .irq_masked (psr_in[7]),
    .fiq_masked (psr_in[6]),
    .grant_vld  (grant_vld),
    .grant_kind (grant_kind)
  );

  assign entry_fire = grant_vld;
  assign bank_wr    = entry_fire && (grant_kind != K_RST);
  assign entry_link = pc_in + {{OFF_PAD{1'b0}}, link_offset(grant_kind, psr_in[5])};
  assign wr_bank    = bank_of_mode(target_mode(grant_kind));
  assign rd_bank    = bank_of_mode(psr_in[4:0]);
  assign ret_fire   = ret_req && !entry_fire && rd_bank[BANK_IW];

  always_comb begin
    entry_psr      = psr_in;
    entry_psr[4:0] = target_mode(grant_kind);
    entry_psr[5]   = 1'b0;
    entry_psr[7]   = 1'b1;
    if (grant_kind == K_RST || grant_kind == K_FIQ) entry_psr[6] = 1'b1;
  end

  exc_bank_file #(.XLEN(XLEN)) u_banks (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bank_wr),
    .wr_idx  (wr_bank[BANK_IW-1:0]),
    .wr_link (entry_link),
    .wr_psr  (psr_in),
    .rd_idx  (rd_bank[BANK_IW-1:0]),
    .rd_link (rd_link),
    .rd_psr  (rd_psr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      psr_out     <= '0;
      link_we     <= 1'b0;
      link_val    <= '0;
      entry_q     <= 1'b0;
    end else begin
      redir_valid <= entry_fire || ret_fire;
      entry_q     <= entry_fire;
      link_we     <= bank_wr;
      link_val    <= bank_wr ? entry_link : '0;
      if (entry_fire) begin
        redir_pc <= {{VEC_PAD{1'b0}}, vector_addr(grant_kind)};
        psr_out  <= entry_psr;
      end else if (ret_fire) begin
        redir_pc <= rd_link - {{OFF_PAD{1'b0}}, return_offset(exc_kind_e'(ret_kind))};
        psr_out  <= rd_psr;
      end else begin
        redir_pc <= '0;
        psr_out  <= '0;
      end
    end
  end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
  import exc_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             grant_vld,
  input exc_kind_e        grant_kind,
  input logic [PSR_W-1:0] psr_in,
  input logic             redir_valid,
  input logic [XLEN-1:0]  redir_pc,
  input logic [PSR_W-1:0] psr_out,
  input logic             link_we,
  input logic             entry_q
);
  p_irq_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && grant_kind == K_IRQ) |-> !psr_in[7]);

  p_fiq_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && grant_kind == K_FIQ) |-> !psr_in[6]);

  p_entry_psr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    entry_q |-> (psr_out[7] && !psr_out[5] && psr_out[4]));

  p_vector_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    entry_q |-> (redir_pc[1:0] == 2'b00 && redir_pc[XLEN-1:5] == '0));

  p_reset_nolink_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && grant_kind == K_RST) |=> !link_we);

  p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |=> redir_valid);

  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !redir_valid |-> (redir_pc == '0 && psr_out == '0 && !link_we));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .grant_vld   (grant_vld),
  .grant_kind  (grant_kind),
  .psr_in      (psr_in),
  .redir_valid (redir_valid),
  .redir_pc    (redir_pc),
  .psr_out     (psr_out),
  .link_we     (link_we),
  .entry_q     (entry_q)
);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  exc_req = '0;
  logic        ret_req = 1'b0;
  logic [2:0]  ret_kind = '0;
  logic [31:0] pc_in = '0;
  logic [31:0] psr_in = '0;
  logic        redir_valid;
  logic [31:0] redir_pc;
  logic [31:0] psr_out;
  logic        link_we;
  logic [31:0] link_val;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_lr   [5];
  logic [31:0] m_spsr [5];

  always #5 clk = ~clk;

  exc_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .ret_req(ret_req),
    .ret_kind(ret_kind), .pc_in(pc_in), .psr_in(psr_in),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .psr_out(psr_out),
    .link_we(link_we), .link_val(link_val)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int bank_idx(input logic [4:0] m);
    if (m == 5'h11) return 0;
    if (m == 5'h12) return 1;
    if (m == 5'h13) return 2;
    if (m == 5'h17) return 3;
    if (m == 5'h1B) return 4;
    return -1;
  endfunction

  // one cycle of stimulus, reference prediction and comparison
  task automatic step(input logic [6:0] rq, input logic rr, input logic [2:0] rk,
                      input logic [31:0] pc, input logic [31:0] psr, input string tag);
    int k = -1;
    int b;
    int off;
    logic        e_v = 1'b0, e_we = 1'b0;
    logic [31:0] e_pc = '0, e_psr = '0, e_link = '0;
    logic [4:0]  mode = '0;
    exc_req = rq; ret_req = rr; ret_kind = rk; pc_in = pc; psr_in = psr;
    if (rq[0]) k = 0;
    else if (rq[4]) k = 4;
    else if (rq[6] && !psr[6]) k = 6;
    else if (rq[5] && !psr[7]) k = 5;
    else if (rq[3]) k = 3;
    else if (rq[1]) k = 1;
    else if (rq[2]) k = 2;
    if (k >= 0) begin
      e_v = 1'b1;
      case (k)
        0: begin mode = 5'h13; e_pc = 32'h00; end
        1: begin mode = 5'h1B; e_pc = 32'h04; end
        2: begin mode = 5'h13; e_pc = 32'h08; end
        3: begin mode = 5'h17; e_pc = 32'h0C; end
        4: begin mode = 5'h17; e_pc = 32'h10; end
        5: begin mode = 5'h12; e_pc = 32'h18; end
        default: begin mode = 5'h11; e_pc = 32'h1C; end
      endcase
      e_psr = psr;
      e_psr[4:0] = mode;
      e_psr[5] = 1'b0;
      e_psr[7] = 1'b1;
      if (k == 0 || k == 6) e_psr[6] = 1'b1;
      if (k != 0) begin
        if (k == 4) off = 8;
        else if (psr[5] && (k == 1 || k == 2)) off = 2;
        else off = 4;
        e_we = 1'b1;
        e_link = pc + off;
        b = bank_idx(mode);
        m_lr[b] = e_link;
        m_spsr[b] = psr;
      end
    end else if (rr && bank_idx(psr[4:0]) >= 0) begin
      b = bank_idx(psr[4:0]);
      off = (rk <= 2) ? 0 : (rk == 4) ? 8 : 4;
      e_v = 1'b1;
      e_pc = m_lr[b] - off;
      e_psr = m_spsr[b];
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "redir_valid", {31'd0, redir_valid}, {31'd0, e_v});
    chk(tag, "redir_pc", redir_pc, e_pc);
    chk(tag, "psr_out", psr_out, e_psr);
    chk(tag, "link_we", {31'd0, link_we}, {31'd0, e_we});
    chk(tag, "link_val", link_val, e_link);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) begin m_lr[i] = '0; m_spsr[i] = '0; end
    @(negedge clk);
    // R1: outputs zero in reset
    chk("R1", "redir_valid", {31'd0, redir_valid}, 32'd0);
    chk("R1", "redir_pc", redir_pc, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step(7'h00, 1'b0, 3'd0, 32'h0, 32'h10, "R1");
    // R1: banks reset to zero, read back by a return
    step(7'h00, 1'b1, 3'd2, 32'h0, 32'h13, "R1");

    // R4: 32-bit state links
    step(7'h04, 1'b0, 3'd0, 32'h1000, 32'h10, "R4");
    step(7'h00, 1'b1, 3'd2, 32'h0, 32'h93, "R9");
    step(7'h02, 1'b0, 3'd0, 32'h1100, 32'h10, "R4");
    step(7'h08, 1'b0, 3'd0, 32'h1200, 32'h10, "R4");
    step(7'h10, 1'b0, 3'd0, 32'h1300, 32'h10, "R4");
    step(7'h20, 1'b0, 3'd0, 32'h1400, 32'h10, "R4");
    step(7'h40, 1'b0, 3'd0, 32'h1500, 32'h10, "R4");
    // R5: 16-bit state links
    step(7'h02, 1'b0, 3'd0, 32'h2000, 32'h30, "R5");
    step(7'h00, 1'b1, 3'd1, 32'h0, 32'h9B, "R9");
    step(7'h04, 1'b0, 3'd0, 32'h2100, 32'h30, "R5");
    step(7'h20, 1'b0, 3'd0, 32'h2200, 32'h30, "R5");
    step(7'h00, 1'b1, 3'd5, 32'h0, 32'h92, "R9");
    step(7'h40, 1'b0, 3'd0, 32'h2300, 32'h30, "R5");
    step(7'h00, 1'b1, 3'd6, 32'h0, 32'hD1, "R8");
    step(7'h08, 1'b0, 3'd0, 32'h2400, 32'h30, "R5");
    step(7'h00, 1'b1, 3'd3, 32'h0, 32'h97, "R9");
    step(7'h10, 1'b0, 3'd0, 32'h2500, 32'hA0000030, "R5");
    step(7'h00, 1'b1, 3'd4, 32'h0, 32'h97, "R8");

    // R2: priority pairs
    step(7'h7F, 1'b0, 3'd0, 32'h3000, 32'h10, "R2");
    step(7'h70, 1'b0, 3'd0, 32'h3100, 32'h10, "R2");
    step(7'h60, 1'b0, 3'd0, 32'h3200, 32'h10, "R2");
    step(7'h28, 1'b0, 3'd0, 32'h3300, 32'h10, "R2");
    step(7'h0A, 1'b0, 3'd0, 32'h3400, 32'h10, "R2");
    step(7'h06, 1'b0, 3'd0, 32'h3500, 32'h10, "R2");

    // R3: masking
    step(7'h20, 1'b0, 3'd0, 32'h4000, 32'h90, "R3");
    step(7'h40, 1'b0, 3'd0, 32'h4100, 32'h50, "R3");
    step(7'h60, 1'b0, 3'd0, 32'h4200, 32'h50, "R3");
    step(7'h24, 1'b0, 3'd0, 32'h4300, 32'h90, "R3");

    // R10: reset entry leaves supervisor bank alone
    step(7'h04, 1'b0, 3'd0, 32'h5000, 32'h10, "R10");
    step(7'h01, 1'b0, 3'd0, 32'h6000, 32'h1F, "R10");
    step(7'h00, 1'b1, 3'd2, 32'h0, 32'hD3, "R10");

    // R11: ignored returns
    step(7'h00, 1'b1, 3'd2, 32'h0, 32'h10, "R11");
    step(7'h00, 1'b1, 3'd2, 32'h0, 32'h1F, "R11");
    step(7'h04, 1'b1, 3'd2, 32'h7000, 32'h93, "R11");
    step(7'h00, 1'b1, 3'd2, 32'h0, 32'h93, "R11");

    // R12: strobe lasts one cycle
    step(7'h00, 1'b0, 3'd0, 32'h0, 32'h10, "R12");
    step(7'h00, 1'b0, 3'd0, 32'h0, 32'h10, "R12");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule